// File: doc/BRIEF.md
# Saturating Dual Event Counter Unit

This block sits next to a cache controller and counts hardware events in two independent counters. Each counter picks one of up to fifteen single-cycle event pulse inputs through a 4-bit source code. A counter that reaches all-ones stays there instead of wrapping, so software polling the unit never sees a small, misleading value after an overflow.

Software reaches the unit through a small word-addressed register port. The port has one global control register, a configuration register per counter and a value register per counter. The per-counter registers come in pairs in descending order: counter 1 sits at the lower address of each pair. Read data is registered and appears one cycle after the read strobe. A global enable gates all counting. A self-clearing control bit zeroes both counters in one write. Each counter can raise a level interrupt while it is saturated, unless its interrupt-mode field masks it.

Top module: `evt_sat_counter_unit`

## Requirements
- R1: After reset, every register reads zero (control, both configurations, both values) and `irq_o` is low.
- R2: Byte addresses are control 0x00, counter 1 configuration 0x04, counter 0 configuration 0x08, counter 1 value 0x0C and counter 0 value 0x10. A configuration register holds the source code in bits [5:2] and the interrupt mode in bits [1:0]. Read data appears on `reg_rdata` on the clock edge that samples `reg_re`.
- R3: A counter at all-ones stays at all-ones when further events arrive; it never wraps to zero.
- R4: Counters change on events only while control bit 0 (enable) is set. With enable clear, events leave both values unchanged.
- R5: Source code 0 means the counter is disabled. Code k from 1 to 15 adds one for each clock cycle in which `evt_in[k-1]` is high.
- R6: With `EXT_EN` = 0, codes 0xA to 0xF count as disabled. With `EXT_EN` = 1 they count their inputs.
- R7: A write to a value register loads the written value. A load takes priority over an event counted in the same cycle.
- R8: Writing 1 to control bit 1 sets both counters to zero. That bit always reads back as zero, and bit 0 keeps the written enable.
- R9: `irq_o` goes high on the clock edge after any counter whose mode field is nonzero is at all-ones. Mode 0 masks that counter.
- R10: Each counter counts only the input its own source code selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | DATA_W | Registered read data |
| evt_in | input | NUM_SRC | Event pulses; bit k-1 is source code k |
| irq_o | output | 1 | Registered saturation interrupt |

## Verification
The bench builds two copies on shared inputs. One copy uses the defaults (32-bit counters, extended codes counted) and the other sets `EXT_EN` to 0, so the same pulses on a high source code show the two variants side by side. Saturation at full 32-bit width is reached by preloading a value register just below all-ones, which also exercises the interrupt and its mask. The bench also drives a register write and an event on the same edge, to show the load wins.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;
  localparam int NCNT      = 2;   // counters in the unit
  localparam int SRC_W     = 4;   // source select width
  localparam int MODE_W    = 2;   // interrupt mode width
  localparam int SRC_LSB   = 2;   // source field position
  localparam int MODE_LSB  = 0;
  localparam int BASIC_MAX = 9;   // highest code always available
  localparam int CTRL_OFS  = 0;
  localparam int CFG_BASE  = 4;
  localparam int VAL_BASE  = CFG_BASE + 4 * NCNT;
  localparam int EN_BIT    = 0;
  localparam int CLR_BIT   = 1;

  // descending pairs: counter NCNT-1 at the lowest word
  function automatic int cfg_addr(input int idx);
    return CFG_BASE + 4 * (NCNT - 1 - idx);
  endfunction

  function automatic int val_addr(input int idx);
    return VAL_BASE + 4 * (NCNT - 1 - idx);
  endfunction
endpackage

// File: rtl/evtcnt_src_mux.sv
module evtcnt_src_mux
  import evtcnt_pkg::*;
#(
  parameter int NUM_SRC = 15,
  parameter bit EXT_EN  = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SRC_W-1:0]   sel,
  input  logic [NUM_SRC-1:0] evt,
  output logic               hit
);
  localparam int PAD_N = 1 << SRC_W;

  logic [PAD_N-1:0] pad;
  logic             code_ok;

  // pad[k] carries the input for code k; code 0 and unused codes read zero
  for (genvar k = 0; k < PAD_N; k++) begin : g_pad
    if (k >= 1 && k <= NUM_SRC) begin : g_src
      assign pad[k] = evt[k-1];
    end else begin : g_none
      assign pad[k] = 1'b0;
    end
  end

  if (EXT_EN) begin : g_ext
    assign code_ok = (sel != '0);
  end else begin : g_basic
    assign code_ok = (sel != '0) && (int'(sel) <= BASIC_MAX);
  end

  assign hit = code_ok && pad[sel];

  // R5: code zero never produces a count request
  p_off_code_r5: assert property (@(posedge clk) disable iff (rst)
    (sel == '0) |-> !hit);

  if (!EXT_EN) begin : g_chk
    // R6: extended codes are inert when the option is off
    p_ext_off_r6: assert property (@(posedge clk) disable iff (rst)
      (int'(sel) > BASIC_MAX) |-> !hit);
  end
endmodule

// File: rtl/evtcnt_sat_ctr.sv
module evtcnt_sat_ctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             inc,
  output logic [CNT_W-1:0] q,
  output logic             sat
);
  localparam logic [CNT_W-1:0] ONES = '1;

  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (ld)
      q <= ld_val;
    else if (inc && q != ONES)
      q <= q + 1'b1;
  end

  assign sat = (q == ONES);

  // R3: a full counter stays full without a load
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (q == ONES && !ld) |=> (q == ONES));

  // R5: one step per counted cycle below the limit
  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    (!ld && inc && q != ONES) |=> (q == $past(q) + 1'b1));

  // R4: no request, no change
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!ld && !inc) |=> $stable(q));

  // R7: a load wins over a same-cycle increment
  p_load_r7: assert property (@(posedge clk) disable iff (rst)
    ld |=> (q == $past(ld_val)));
endmodule

// File: rtl/evt_sat_counter_unit.sv
module evt_sat_counter_unit
  import evtcnt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5,
  parameter int NUM_SRC = 15,
  parameter bit EXT_EN  = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_we,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic               reg_re,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_SRC-1:0] evt_in,
  output logic               irq_o
);
  localparam int CFG_W = SRC_LSB + SRC_W;

  logic                en_q;
  logic                ctrl_wr;
  logic                clr_all;
  logic [SRC_W-1:0]    src_q  [NCNT];
  logic [MODE_W-1:0]   mode_q [NCNT];
  logic [CNT_W-1:0]    cnt_q  [NCNT];
  logic [NCNT-1:0]     sat_v;
  logic [NCNT-1:0]     irq_v;
  logic [DATA_W-1:0]   rd_next;

  assign ctrl_wr = reg_we && (reg_addr == ADDR_W'(CTRL_OFS));
  assign clr_all = ctrl_wr && reg_wdata[CLR_BIT];

  always_ff @(posedge clk) begin
    if (rst)
      en_q <= 1'b0;
    else if (ctrl_wr)
      en_q <= reg_wdata[EN_BIT];
  end

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    logic cfg_wr, val_wr, hit, ld;
    logic [CNT_W-1:0] ld_val;

    assign cfg_wr = reg_we && (reg_addr == ADDR_W'(cfg_addr(i)));
    assign val_wr = reg_we && (reg_addr == ADDR_W'(val_addr(i)));

    always_ff @(posedge clk) begin
      if (rst) begin
        src_q[i]  <= '0;
        mode_q[i] <= '0;
      end else if (cfg_wr) begin
        src_q[i]  <= reg_wdata[SRC_LSB +: SRC_W];
        mode_q[i] <= reg_wdata[MODE_LSB +: MODE_W];
      end
    end

    evtcnt_src_mux #(.NUM_SRC(NUM_SRC), .EXT_EN(EXT_EN)) u_mux (
      .clk (clk),
      .rst (rst),
      .sel (src_q[i]),
      .evt (evt_in),
      .hit (hit)
    );

    assign ld     = clr_all || val_wr;
    assign ld_val = clr_all ? '0 : reg_wdata[CNT_W-1:0];

    evtcnt_sat_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk    (clk),
      .rst    (rst),
      .ld     (ld),
      .ld_val (ld_val),
      .inc    (en_q && hit),
      .q      (cnt_q[i]),
      .sat    (sat_v[i])
    );

    assign irq_v[i] = sat_v[i] && (mode_q[i] != '0);
  end

  always_comb begin
    rd_next = '0;
    if (reg_addr == ADDR_W'(CTRL_OFS))
      rd_next[EN_BIT] = en_q;
    for (int i = 0; i < NCNT; i++) begin
      if (reg_addr == ADDR_W'(cfg_addr(i)))
        rd_next[CFG_W-1:0] = {src_q[i], mode_q[i]};
      if (reg_addr == ADDR_W'(val_addr(i)))
        rd_next[CNT_W-1:0] = cnt_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      if (reg_re)
        reg_rdata <= rd_next;
      irq_o <= |irq_v;
    end
  end

  // R8: the clear strobe empties both counters on the next edge
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (cnt_q[0] == '0 && cnt_q[1] == '0));

  // R9: masked modes never raise the interrupt
  p_irq_mask_r9: assert property (@(posedge clk) disable iff (rst)
    (mode_q[0] == '0 && mode_q[1] == '0) |=> !irq_o);

  // R4: with enable low and no writes, counts hold
  p_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !reg_we) |=> ($stable(cnt_q[0]) && $stable(cnt_q[1])));
endmodule

// File: tb/sim_evt_sat_counter_unit.sv
`timescale 1ns/1ps
module sim_evt_sat_counter_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_re = 1'b0;
  logic [14:0] evt_in = '0;
  logic [31:0] rdata0, rdata1;
  logic        irq0, irq1;
  int checks = 0;
  int errors = 0;
  logic [31:0] got0, got1;

  localparam logic [4:0] A_CTRL = 5'h00, A_CFG1 = 5'h04, A_CFG0 = 5'h08,
                         A_VAL1 = 5'h0C, A_VAL0 = 5'h10;

  always #2.5 clk = ~clk;

  evt_sat_counter_unit u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_rdata(rdata0),
    .evt_in(evt_in), .irq_o(irq0));

  evt_sat_counter_unit #(.EXT_EN(1'b0)) u1 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_rdata(rdata1),
    .evt_in(evt_in), .irq_o(irq1));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    @(posedge clk); #1;
    got0 = rdata0; got1 = rdata1;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic pulse(input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      evt_in[idx] = 1'b1;
      @(negedge clk);
      evt_in[idx] = 1'b0;
    end
  endtask

  task automatic t_reset();
    rd(A_CTRL); chk("R1 ctrl", got0, 32'h0);
    rd(A_CFG0); chk("R1 cfg0", got0, 32'h0);
    rd(A_CFG1); chk("R1 cfg1", got0, 32'h0);
    rd(A_VAL0); chk("R1 val0", got0, 32'h0);
    rd(A_VAL1); chk("R1 val1", got0, 32'h0);
    chk("R1 irq", {31'b0, irq0}, 32'h0);
  endtask

  task automatic t_map_and_gate();
    wr(A_CFG0, 32'h05);          // src 1, mode 1
    wr(A_CFG1, 32'h0A);          // src 2, mode 2
    rd(A_CFG0); chk("R2 cfg0 readback", got0, 32'h05);
    rd(A_CFG1); chk("R2 cfg1 readback", got0, 32'h0A);
    pulse(0, 3);
    rd(A_VAL0); chk("R4 disabled val0", got0, 32'h0);
  endtask

  task automatic t_count_sel();
    wr(A_CTRL, 32'h1);
    pulse(0, 3);
    pulse(1, 5);
    pulse(5, 2);                 // selected by nobody
    rd(A_VAL0); chk("R5 R10 val0 counts src1", got0, 32'd3);
    rd(A_VAL1); chk("R10 val1 counts src2 at low address", got0, 32'd5);
  endtask

  task automatic t_clear();
    wr(A_CTRL, 32'h3);
    rd(A_VAL0); chk("R8 val0 cleared", got0, 32'h0);
    rd(A_VAL1); chk("R8 val1 cleared", got0, 32'h0);
    rd(A_CTRL); chk("R8 ctrl bit1 reads zero", got0, 32'h1);
  endtask

  task automatic t_src_off();
    wr(A_CFG1, 32'h00);          // code 0
    pulse(1, 2);
    rd(A_VAL1); chk("R5 code0 no count", got0, 32'h0);
  endtask

  task automatic t_write_priority();
    @(negedge clk);
    evt_in[0] = 1'b1; reg_we = 1'b1; reg_addr = A_VAL0; reg_wdata = 32'd100;
    @(negedge clk);
    evt_in[0] = 1'b0; reg_we = 1'b0;
    rd(A_VAL0); chk("R7 write beats event", got0, 32'd100);
    pulse(0, 1);
    rd(A_VAL0); chk("R7 count from loaded value", got0, 32'd101);
  endtask

  task automatic t_saturate_irq();
    wr(A_VAL0, 32'hFFFF_FFFE);
    pulse(0, 1);
    chk("R9 irq not yet", {31'b0, irq0}, 32'h0);
    @(posedge clk); #1;
    chk("R9 irq raised", {31'b0, irq0}, 32'h1);
    pulse(0, 3);
    rd(A_VAL0); chk("R3 saturated no wrap", got0, 32'hFFFF_FFFF);
    wr(A_CFG0, 32'h04);          // src 1, mode 0
    @(posedge clk); #1;
    chk("R9 mode0 masks irq", {31'b0, irq0}, 32'h0);
  endtask

  task automatic t_ext();
    wr(A_VAL0, 32'h0);
    wr(A_CFG0, 32'h28);          // code 0xA
    pulse(9, 4);
    rd(A_VAL0);
    chk("R6 ext code counts", got0, 32'd4);
    chk("R6 ext code disabled variant", got1, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_map_and_gate();
    t_count_sel();
    t_clear();
    t_src_off();
    t_write_priority();
    t_saturate_irq();
    t_ext();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule